// File: doc/BRIEF.md
# DMA Channel Counting Semaphore

This block holds an 8-bit credit count for one DMA channel. It keeps the software thread and the chained-descriptor engine in step. Software posts credits by writing an amount into a 32-bit register. The engine takes one credit at a time through a request/acknowledge pair. When no credit is left, the engine waits: its request stays pending, and the block drives a stall status until software adds credits.

A software add and an engine decrement can fall in the same clock. In that case they are merged into a single net update, so neither is lost. Adds that would go past 255 clamp at 255 and raise a sticky overflow flag. Software clears that flag by writing a one to its bit.

Top module: `dma_credit_sema`

## Requirements
- R1: After reset the count is 0, the overflow flag is 0, and `reg_rdata` reads 0.
- R2: A write with no acknowledged decrement in the same cycle adds `reg_wdata[7:0]` to the count at the next clock edge, unless the sum exceeds 255.
- R3: A pending `dec_req` is acknowledged in the same cycle (`dec_ack` high) whenever the count is nonzero or a nonzero add is written in that cycle. Each acknowledge removes exactly one unit.
- R4: When an add and an acknowledged decrement share a cycle, the count changes by the add minus one. For example, adding 2 with a concurrent decrement raises the count by 1.
- R5: A `dec_req` while the count is 0 and no nonzero add is written is not acknowledged. The count stays 0 and does not wrap.
- R6: `stalled` is high exactly when `dec_req` is high and `dec_ack` is low.
- R7: If the net result would exceed 255, the count becomes 255 and the overflow flag (`reg_rdata[8]`) is set. Writing 1 to bit 8 clears the flag. A new overflow in the same cycle as a clear leaves the flag set.
- R8: The read word carries the count in bits 23:16 and the overflow flag in bit 8. Bits 7:0 (the increment field) and all other bits read as 0.
- R9: Write data in bits 31:9 has no effect on the count or the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data: add amount in 7:0, flag clear in bit 8 |
| reg_rdata | output | 32 | Read word: count in 23:16, overflow flag in bit 8 |
| dec_req | input | 1 | Engine asks to take one credit |
| dec_ack | output | 1 | Credit granted this cycle |
| stalled | output | 1 | Request pending but not granted |

## Verification
The hardest case to reach is a stalled request that is granted in the very cycle software's add arrives. The bench reaches it by holding `dec_req` high at count zero for a cycle, then writing an add while the request is still held. It checks that the grant appears combinationally and that the count ends at the add minus one.

The set-versus-clear race on the overflow flag is reached the same way. The bench first fills the count to 255, then writes a word that both adds 1 and clears the flag.

// File: rtl/dma_credit_sema.sv
module dma_credit_sema #(
  parameter int CNT_W   = 8,
  parameter int CNT_LSB = 16,
  parameter int OVF_BIT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        dec_req,
  output logic        dec_ack,
  output logic        stalled
);
  localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic [CNT_W-1:0] add;
  logic [CNT_W:0]   avail, net;
  logic             sat;

  assign add     = reg_wr ? reg_wdata[CNT_W-1:0] : '0;
  assign avail   = {1'b0, cnt_q} + {1'b0, add};
  assign dec_ack = dec_req && (avail != '0);
  assign stalled = dec_req && !dec_ack;
  assign net     = avail - {{CNT_W{1'b0}}, dec_ack};
  assign sat     = net > CNT_MAX;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= sat ? CNT_MAX[CNT_W-1:0] : net[CNT_W-1:0];
      if (sat)
        ovf_q <= 1'b1;
      else if (reg_wr && reg_wdata[OVF_BIT])
        ovf_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    reg_rdata[CNT_LSB +: CNT_W] = cnt_q;
    reg_rdata[OVF_BIT] = ovf_q;
  end
endmodule

module dma_credit_sema_chk #(parameter int CNT_W = 8) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [CNT_W-1:0] add,
  input logic             dec_req,
  input logic             dec_ack,
  input logic             stalled,
  input logic [CNT_W-1:0] cnt,
  input logic             ovf
);
  localparam int MAXV = (1 << CNT_W) - 1;

  AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ack && !reg_wr) |=> cnt == $past(cnt) - 1'b1); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && (!reg_wr || add == '0)) |-> !dec_ack); // R5
  AST_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !dec_ack && (int'(cnt) + int'(add) <= MAXV)) |=> cnt == $past(cnt) + $past(add)); // R2
  AST_NET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && dec_ack && (int'(cnt) + int'(add) - 1 <= MAXV)) |=> int'(cnt) == int'($past(cnt)) + int'($past(add)) - 1); // R4
  AST_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (int'(cnt) + int'(add) - int'(dec_ack) > MAXV)) |=> (int'(cnt) == MAXV && ovf)); // R7
  AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> (dec_req && cnt == '0)); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !dec_req) |=> $stable(cnt)); // R9
endmodule

bind dma_credit_sema dma_credit_sema_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .add(reg_wdata[CNT_W-1:0]),
  .dec_req(dec_req), .dec_ack(dec_ack), .stalled(stalled), .cnt(cnt_q), .ovf(ovf_q)
);

// File: tb/dma_credit_sema_tb.sv
module dma_credit_sema_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, dec_req = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic dec_ack, stalled;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  dma_credit_sema u_dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dec_req(dec_req), .dec_ack(dec_ack), .stalled(stalled));

  typedef struct packed {
    logic wr; logic [31:0] data; logic req; logic ack; logic stall; logic [7:0] cnt;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b0, 32'h0,        1'b1, 1'b0, 1'b1, 8'd0}, // R5 R6 stall at zero
    '{1'b1, 32'h3,        1'b1, 1'b1, 1'b0, 8'd2}, // R3 R4 wake by same-cycle add
    '{1'b0, 32'h0,        1'b1, 1'b1, 1'b0, 8'd1}, // R3
    '{1'b1, 32'h2,        1'b1, 1'b1, 1'b0, 8'd2}, // R4 add 2 minus 1
    '{1'b1, 32'h00FF0000, 1'b0, 1'b0, 1'b0, 8'd2}, // R9 count field ignored
    '{1'b1, 32'h5,        1'b0, 1'b0, 1'b0, 8'd7}, // R2
    '{1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 8'd7}, // R2 idle hold
    '{1'b0, 32'h0,        1'b1, 1'b1, 1'b0, 8'd6}, // R3
    '{1'b0, 32'h0,        1'b1, 1'b1, 1'b0, 8'd5}  // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [31:0] d, input logic rq,
                      input logic eack, input logic estall, input string req);
    @(negedge clk);
    reg_wr = wr; reg_wdata = d; dec_req = rq;
    #1;
    chk({req, " ack"}, {31'd0, dec_ack}, {31'd0, eack});
    chk({req, " stall"}, {31'd0, stalled}, {31'd0, estall});
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_wdata = '0; dec_req = 1'b0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #10;
    chk("R1 reset rdata", reg_rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    chk("R1 after release", reg_rdata, 32'h0);
    for (int i = 0; i < 9; i++) begin
      step(VEC[i].wr, VEC[i].data, VEC[i].req, VEC[i].ack, VEC[i].stall, $sformatf("vec%0d R3/R6", i));
      chk($sformatf("vec%0d R2/R4/R5/R9 count", i), {24'd0, reg_rdata[23:16]}, {24'd0, VEC[i].cnt});
    end
    step(1'b0, 0, 1'b0, 1'b0, 1'b0, "R8 idle");
    chk("R8 layout count=5", reg_rdata, 32'h0005_0000);
    step(1'b1, 32'hFF, 1'b0, 1'b0, 1'b0, "R7 overflow add");
    chk("R7 saturate with flag", reg_rdata, 32'h00FF_0100);
    step(1'b1, 32'h100, 1'b0, 1'b0, 1'b0, "R7 clear");
    chk("R7 flag cleared", reg_rdata, 32'h00FF_0000);
    step(1'b1, 32'h1, 1'b1, 1'b1, 1'b0, "R4 full add with dec");
    chk("R4 net keeps 255 no flag", reg_rdata, 32'h00FF_0000);
    step(1'b1, 32'h101, 1'b0, 1'b0, 1'b0, "R7 set vs clear");
    chk("R7 set wins over clear", reg_rdata, 32'h00FF_0100);
    step(1'b1, 32'hFFFF_FE00, 1'b0, 1'b0, 1'b0, "R9 upper bits");
    chk("R9 upper bits ignored", reg_rdata, 32'h00FF_0100);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule